// File: doc/BRIEF.md
# Prescaled PWM Event Trigger

This block sits beside a PWM time base and turns its event strobes into two trigger outputs. One is a level interrupt request for the processor. The other is a one-clock start-of-conversion pulse for an ADC. The time base supplies single-cycle strobes for counter-at-zero, counter-at-period, compare A match and compare B match, together with a flag that is high while the counter counts up.

Each output has its own source selector and its own event divider. The divider lets the output fire on every qualifying event, or only on every Nth one, with N from 1 to 15. A divider setting of zero turns the output off. The interrupt stays pending until software pulses a clear input. Changing either configuration field of an output restarts that output's event count. The reset is asynchronous and active low, and the block releases it internally two clock edges after the input reset goes high.

Top module: `pwm_evt_trig`

## Requirements
- R1: While reset is held, and after it is released with both selectors at 0, `irq_req` and `soc_pulse` are low.
- R2: The source code selects the qualifying event: 0 none, 1 zero, 2 period, 3 zero or period, 4 compare A while counting up, 5 compare A while counting down, 6 compare B while counting up, 7 compare B while counting down.
- R3: The direction-qualified codes (4 to 7) ignore a compare strobe that arrives while `cnt_up` is in the other direction.
- R4: With a divider setting of N (1 to 15), an output fires on the Nth qualifying event after its count last restarted, and its count then returns to zero. The effect appears on the output one clock after the strobe.
- R5: A divider setting of 0 keeps the output from firing, whatever the strobes are.
- R6: `soc_pulse` is high for exactly one clock for each time its prescaled condition is met.
- R7: `irq_req` goes high when its prescaled condition is met and stays high until `irq_clr` is pulsed. If a new firing and a clear come in the same cycle, the firing wins.
- R8: Firings while `irq_req` is already pending are not queued. A single clear drops the request, and it stays low until a later firing.
- R9: A change of an output's source or divider setting restarts that output's event count from zero. A strobe in the same cycle as the change is not counted.
- R10: The two outputs count and fire independently of each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_zero | input | 1 | Strobe: counter equals zero |
| ev_period | input | 1 | Strobe: counter equals period |
| ev_cmpa | input | 1 | Strobe: counter equals compare A |
| ev_cmpb | input | 1 | Strobe: counter equals compare B |
| cnt_up | input | 1 | High while the counter counts up |
| irq_src | input | 3 | Interrupt source code (R2) |
| irq_div | input | DIV_W | Interrupt divider setting, 0 = off |
| irq_clr | input | 1 | Clears the pending interrupt |
| soc_src | input | 3 | Conversion-start source code (R2) |
| soc_div | input | DIV_W | Conversion-start divider setting, 0 = off |
| irq_req | output | 1 | Pending interrupt request (level) |
| soc_pulse | output | 1 | One-clock conversion-start pulse |

## Verification
The hardest situations to reach are the ones where several things meet in one cycle. A configuration change can land on the same clock as a qualifying strobe. A clear can land on the same clock as a new interrupt firing. A count can sit part-way to its divider value when the setting changes. Random strobes alone seldom line these up, so the stimulus holds the strobe density high and flips the direction flag, the configuration fields and the clear input at random within phases. A cycle-accurate model tracks each output's count, so every such coincidence is checked when it happens. Short directed sequences place the same-cycle cases on purpose.

// File: rtl/pet_pkg.sv
package pet_pkg;

  typedef enum logic [2:0] {
    SRC_OFF    = 3'd0,
    SRC_ZERO   = 3'd1,
    SRC_PRD    = 3'd2,
    SRC_ZP     = 3'd3,
    SRC_CA_UP  = 3'd4,
    SRC_CA_DN  = 3'd5,
    SRC_CB_UP  = 3'd6,
    SRC_CB_DN  = 3'd7
  } pet_src_e;

  typedef struct packed {
    logic zero;
    logic period;
    logic cmpa;
    logic cmpb;
  } pet_ev_t;

  localparam int unsigned NUM_TRIG = 2;
  localparam int unsigned TRIG_IRQ = 0;
  localparam int unsigned TRIG_SOC = 1;

endpackage

// File: rtl/pet_rst_sync.sv
module pet_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/pet_event_sel.sv
module pet_event_sel
  import pet_pkg::*;
(
  input  pet_src_e src_i,
  input  pet_ev_t  ev_i,
  input  logic     up_i,
  output logic     hit_o
);

  always_comb begin
    unique case (src_i)
      SRC_OFF:   hit_o = 1'b0;
      SRC_ZERO:  hit_o = ev_i.zero;
      SRC_PRD:   hit_o = ev_i.period;
      SRC_ZP:    hit_o = ev_i.zero | ev_i.period;
      SRC_CA_UP: hit_o = ev_i.cmpa & up_i;
      SRC_CA_DN: hit_o = ev_i.cmpa & ~up_i;
      SRC_CB_UP: hit_o = ev_i.cmpb & up_i;
      SRC_CB_DN: hit_o = ev_i.cmpb & ~up_i;
      default:   hit_o = 1'b0;
    endcase
  end

endmodule

// File: rtl/pet_prescaler.sv
module pet_prescaler
  import pet_pkg::*;
#(
  parameter int unsigned DIV_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  pet_src_e         src_i,
  input  logic [DIV_W-1:0] div_i,
  input  logic             hit_i,
  output logic             fire_o
);

  logic [DIV_W-1:0] cnt_q, cnt_d;
  logic [DIV_W-1:0] div_q;
  pet_src_e         src_q;
  logic             cfg_chg;
  logic [DIV_W-1:0] cnt_inc;

  always_comb begin
    cfg_chg = (src_i != src_q) || (div_i != div_q);
    cnt_inc = cnt_q + 1'b1;
    fire_o  = 1'b0;
    cnt_d   = cnt_q;
    if (cfg_chg || (div_i == '0)) begin
      cnt_d = '0;
    end else if (hit_i) begin
      if (cnt_inc == div_i) begin
        cnt_d  = '0;
        fire_o = 1'b1;
      end else begin
        cnt_d = cnt_inc;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      div_q <= '0;
      src_q <= SRC_OFF;
    end else begin
      cnt_q <= cnt_d;
      div_q <= div_i;
      src_q <= src_i;
    end
  end

  // R4: the count stays below an active divider setting
  assert_cnt_below_div_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (div_q != '0) |-> (cnt_q < div_q));

  // R4: the count restarts after each firing
  assert_cnt_restart_R4: assert property (@(posedge clk) disable iff (!rst_n)
    fire_o |=> (cnt_q == '0));

  // R9: a configuration change restarts the count
  assert_cfg_restart_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_chg |=> (cnt_q == '0));

  // R5: a zero setting holds the count at zero
  assert_off_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (div_q == '0) |-> (cnt_q == '0));

endmodule

// File: rtl/pwm_evt_trig.sv
module pwm_evt_trig
  import pet_pkg::*;
#(
  parameter int unsigned DIV_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ev_zero,
  input  logic             ev_period,
  input  logic             ev_cmpa,
  input  logic             ev_cmpb,
  input  logic             cnt_up,
  input  logic [2:0]       irq_src,
  input  logic [DIV_W-1:0] irq_div,
  input  logic             irq_clr,
  input  logic [2:0]       soc_src,
  input  logic [DIV_W-1:0] soc_div,
  output logic             irq_req,
  output logic             soc_pulse
);

  logic                      rst_int_n;
  pet_ev_t                   ev;
  pet_src_e [NUM_TRIG-1:0]   src_v;
  logic [NUM_TRIG-1:0][DIV_W-1:0] div_v;
  logic [NUM_TRIG-1:0]       hit_v;
  logic [NUM_TRIG-1:0]       fire_v;
  logic                      irq_q, irq_d;
  logic                      soc_q, soc_d;

  pet_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  always_comb begin
    ev.zero   = ev_zero;
    ev.period = ev_period;
    ev.cmpa   = ev_cmpa;
    ev.cmpb   = ev_cmpb;
    src_v[TRIG_IRQ] = pet_src_e'(irq_src);
    src_v[TRIG_SOC] = pet_src_e'(soc_src);
    div_v[TRIG_IRQ] = irq_div;
    div_v[TRIG_SOC] = soc_div;
  end

  for (genvar g = 0; g < NUM_TRIG; g++) begin : g_trig
    pet_event_sel u_sel (
      .src_i (src_v[g]),
      .ev_i  (ev),
      .up_i  (cnt_up),
      .hit_o (hit_v[g])
    );
    pet_prescaler #(.DIV_W(DIV_W)) u_div (
      .clk    (clk),
      .rst_n  (rst_int_n),
      .src_i  (src_v[g]),
      .div_i  (div_v[g]),
      .hit_i  (hit_v[g]),
      .fire_o (fire_v[g])
    );
  end

  always_comb begin
    irq_d = fire_v[TRIG_IRQ] | (irq_q & ~irq_clr);
    soc_d = fire_v[TRIG_SOC];
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      irq_q <= 1'b0;
      soc_q <= 1'b0;
    end else begin
      irq_q <= irq_d;
      soc_q <= soc_d;
    end
  end

  assign irq_req   = irq_q;
  assign soc_pulse = soc_q;

  // R7: a pending request only drops after a clear
  assert_irq_hold_R7: assert property (@(posedge clk) disable iff (!rst_int_n)
    $fell(irq_q) |-> $past(irq_clr));

  // R5: no conversion pulse comes from a zero setting
  assert_soc_off_R5: assert property (@(posedge clk) disable iff (!rst_int_n)
    soc_q |-> ($past(soc_div) != '0));

  // R5: no interrupt rises from a zero setting
  assert_irq_off_R5: assert property (@(posedge clk) disable iff (!rst_int_n)
    $rose(irq_q) |-> ($past(irq_div) != '0));

  // R2: an off selector never raises the request
  assert_irq_src_off_R2: assert property (@(posedge clk) disable iff (!rst_int_n)
    $rose(irq_q) |-> ($past(irq_src) != 3'd0));

endmodule

// File: tb/pwm_evt_trig_bench.sv
`timescale 1ns/100ps
module pwm_evt_trig_bench;

  localparam int DIV_W = 4;

  logic clk = 1'b0;
  logic rst_n;
  logic ev_zero, ev_period, ev_cmpa, ev_cmpb, cnt_up;
  logic [2:0] irq_src, soc_src;
  logic [DIV_W-1:0] irq_div, soc_div;
  logic irq_clr;
  logic irq_req, soc_pulse;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  string cur_req = "R1";

  int m_cnt[2], m_src[2], m_div[2];
  bit exp_irq = 0, exp_soc = 0;

  always #2.5 clk = ~clk;

  pwm_evt_trig #(.DIV_W(DIV_W)) u_pwm_evt_trig (
    .clk(clk), .rst_n(rst_n),
    .ev_zero(ev_zero), .ev_period(ev_period), .ev_cmpa(ev_cmpa), .ev_cmpb(ev_cmpb),
    .cnt_up(cnt_up),
    .irq_src(irq_src), .irq_div(irq_div), .irq_clr(irq_clr),
    .soc_src(soc_src), .soc_div(soc_div),
    .irq_req(irq_req), .soc_pulse(soc_pulse)
  );

  function automatic bit src_hit(int s);
    case (s)
      1: return ev_zero;
      2: return ev_period;
      3: return ev_zero | ev_period;
      4: return ev_cmpa & cnt_up;
      5: return ev_cmpa & !cnt_up;
      6: return ev_cmpb & cnt_up;
      7: return ev_cmpb & !cnt_up;
      default: return 0;
    endcase
  endfunction

  function automatic bit model_step(int k, int s, int d);
    bit f = 0;
    if (s != m_src[k] || d != m_div[k] || d == 0) m_cnt[k] = 0;
    else if (src_hit(s)) begin
      if (m_cnt[k] + 1 == d) begin m_cnt[k] = 0; f = 1; end
      else m_cnt[k]++;
    end
    m_src[k] = s; m_div[k] = d;
    return f;
  endfunction

  task automatic check(string what, bit act, bit exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual %0b expected %0b at %0t", cur_req, what, act, exp, $time);
    end
  endtask

  // one clock: inputs already driven at the negedge; model at posedge; compare at negedge
  task automatic tick();
    bit fi, fs;
    @(posedge clk);
    fi = model_step(0, int'(irq_src), int'(irq_div));
    fs = model_step(1, int'(soc_src), int'(soc_div));
    exp_soc = fs;
    exp_irq = fi ? 1'b1 : (irq_clr ? 1'b0 : exp_irq);
    @(negedge clk);
    check("soc_pulse", soc_pulse, exp_soc);
    check("irq_req", irq_req, exp_irq);
  endtask

  task automatic idle_strobes();
    ev_zero = 0; ev_period = 0; ev_cmpa = 0; ev_cmpb = 0; irq_clr = 0;
  endtask

  task automatic rand_strobes(int dens);
    ev_zero   = ($urandom_range(99) < dens);
    ev_period = ($urandom_range(99) < dens);
    ev_cmpa   = ($urandom_range(99) < dens);
    ev_cmpb   = ($urandom_range(99) < dens);
    cnt_up    = $urandom_range(1);
  endtask

  task automatic rand_phase(int n, int dens, int cfg_pct, int clr_pct, bit allow_zero);
    for (int i = 0; i < n; i++) begin
      rand_strobes(dens);
      if ($urandom_range(99) < cfg_pct) begin
        irq_src = 3'($urandom_range(7));
        irq_div = 4'(allow_zero ? $urandom_range(15) : $urandom_range(15, 1));
      end
      if ($urandom_range(99) < cfg_pct) begin
        soc_src = 3'($urandom_range(7));
        soc_div = 4'(allow_zero ? $urandom_range(15) : $urandom_range(15, 1));
      end
      irq_clr = ($urandom_range(99) < clr_pct);
      tick();
    end
  endtask

  initial begin
    int socs;
    rst_n = 0; cnt_up = 1;
    idle_strobes();
    irq_src = 0; soc_src = 0; irq_div = 0; soc_div = 0;
    m_cnt = '{0, 0}; m_src = '{0, 0}; m_div = '{0, 0};
    repeat (3) @(negedge clk);
    cur_req = "R1";
    check("irq_req in reset", irq_req, 0);
    check("soc_pulse in reset", soc_pulse, 0);
    rst_n = 1;
    repeat (5) tick();

    // R4 directed: every third zero strobe gives one pulse on the next clock
    cur_req = "R4";
    soc_src = 3'd1; soc_div = 4'd3; irq_src = 3'd1; irq_div = 4'd3;
    tick();
    socs = 0;
    for (int i = 0; i < 9; i++) begin
      ev_zero = 1; tick(); socs += soc_pulse;
      ev_zero = 0; tick(); socs += soc_pulse;
    end
    checks++;
    if (socs != 3) begin
      errors++;
      $display("FAIL R4 pulse count actual %0d expected %0d", socs, 3);
    end

    // R7 directed: clear and a new firing in the same cycle, firing wins
    cur_req = "R7";
    irq_div = 4'd1; soc_div = 4'd1; tick();
    ev_zero = 1; tick();
    ev_zero = 1; irq_clr = 1; tick();
    check("set wins over clear", irq_req, 1);
    ev_zero = 0; irq_clr = 1; tick();
    ev_zero = 0; irq_clr = 0; tick();
    check("cleared stays low", irq_req, 0);

    // R8 directed: several firings while pending, one clear drops it
    cur_req = "R8";
    for (int i = 0; i < 3; i++) begin ev_zero = 1; tick(); ev_zero = 0; tick(); end
    irq_clr = 1; tick(); irq_clr = 0;
    repeat (3) tick();
    check("no queued request", irq_req, 0);

    // R9 directed: count of 2 then divider change with a strobe in the same cycle
    cur_req = "R9";
    soc_src = 3'd2; soc_div = 4'd4; tick();
    ev_period = 1; tick(); tick(); ev_period = 0; tick();
    soc_div = 4'd3; ev_period = 1; tick();
    tick(); tick();
    ev_period = 0; tick();
    check("restart after change", soc_pulse, 0);
    ev_period = 1; tick(); ev_period = 0; tick();
    check("third strobe after change", soc_pulse, 0);
    idle_strobes();

    // R2 and R3: each source code with direction flips, divider 1
    cur_req = "R2";
    for (int s = 0; s < 8; s++) begin
      cur_req = (s >= 4) ? "R3" : "R2";
      irq_src = 3'(s); soc_src = 3'(7 - s); irq_div = 4'd1; soc_div = 4'd1;
      for (int i = 0; i < 40; i++) begin
        rand_strobes(40); irq_clr = $urandom_range(1); tick();
      end
    end

    // R5: divider zero on both outputs under dense strobes
    cur_req = "R5";
    idle_strobes(); irq_clr = 1; tick(); irq_clr = 0;
    irq_div = 0; soc_div = 0;
    for (int i = 0; i < 80; i++) begin
      rand_strobes(90);
      irq_src = 3'($urandom_range(7)); soc_src = 3'($urandom_range(7));
      tick();
    end

    // R6 and R10: fixed configurations, different per output
    cur_req = "R6";
    irq_src = 3'd3; irq_div = 4'd5; soc_src = 3'd4; soc_div = 4'd2;
    rand_phase(300, 50, 0, 5, 0);
    cur_req = "R10";
    irq_src = 3'd7; irq_div = 4'd15; soc_src = 3'd1; soc_div = 4'd1;
    rand_phase(300, 60, 0, 3, 0);

    // R9: frequent configuration changes
    cur_req = "R9";
    rand_phase(1500, 50, 15, 10, 1);

    // R4: long run with rare changes, all settings
    cur_req = "R4";
    rand_phase(4000, 35, 1, 4, 1);

    // R7: sparse clears
    cur_req = "R7";
    rand_phase(1000, 30, 2, 1, 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule